// File: doc/BRIEF.md
# First-Level Cache Timing Controller

This block sequences the timing of a first-level cache that serves processor loads and stores strictly one at a time. A request arrives on a valid/ready channel with a command (load or store), a requester tag and a byte address. The controller looks the address up in a direct-mapped tag store. A hit is answered after a fixed latency for that command. A miss evicts the resident line, writes it back to the parent level if it is dirty, fetches the new line and then answers. No data moves through the block. It models only tags, dirty state and cycle timing, so a processor model can be given realistic cache delays.

The parent level is an abstract port. Requests go out through a two-entry queue, so a write-back and the fetch that follows it can be issued in consecutive cycles. Replies come back as single-cycle pulses that are either a write acknowledge or a fetch completion. Write-back or write-through policy and the two hit latencies are parameters.

Top module: `l1_timing_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `par_req_valid` are 0.
- R2: A request is accepted only while the controller is idle. `req_ready` stays 0 from the cycle after an accept until the reply cycle has passed, so requests are served one at a time in arrival order.
- R3: The reply pulse `rsp_valid` lasts one cycle and echoes `req_id` and `req_store` (0 = load, 1 = store). It comes LAT_LOAD or LAT_STORE cycles after the timing origin. The origin is the accept cycle when no parent traffic is needed, and otherwise the cycle of the last parent reply.
- R4: A miss sends the parent a fetch (`par_req_write`=0) whose `par_req_store` carries the original command and whose `par_req_addr` is the line address, with its OFS_W low bits zero.
- R5: If the victim line is valid and dirty, a write (`par_req_write`=1, `par_req_store`=1) of its line address {victim tag, index, OFS_W zeros} is issued before the fetch.
- R6: Under write-back a store hit or a store fill marks the line dirty, and a load fill leaves it clean. Under write-through no line ever becomes dirty, so no victim write is ever issued.
- R7: Under write-back a write acknowledge (`par_rsp_fetch`=0) received while waiting does not advance the controller. Only the fetch completion (`par_rsp_fetch`=1) starts the latency count.
- R8: Under write-through a store hit first issues a write of its line address, waits for the acknowledge, and then counts LAT_STORE.
- R9: Under write-through a store miss fetches the line, then issues the write of its line address, and replies LAT_STORE cycles after that write is acknowledged.
- R10: The parent request queue holds two entries. An entry stays valid with a stable address while `par_req_ready` is 0, and entries leave in issue order.
- R11: After reset every line is invalid, so the first access to any index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_id | input | ID_W | Requester tag |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_store | output | 1 | Command of the completed request |
| rsp_id | output | ID_W | Requester tag of the completed request |
| par_req_valid | output | 1 | Parent request queue not empty |
| par_req_ready | input | 1 | Parent takes the head entry |
| par_req_write | output | 1 | 1 = line write, 0 = fetch |
| par_req_store | output | 1 | Fetch command type; 1 for writes |
| par_req_addr | output | ADDR_W | Line address |
| par_rsp_valid | input | 1 | Parent reply pulse |
| par_rsp_fetch | input | 1 | 1 = fetch complete, 0 = write acknowledge |

## Verification
Two instances, one write-back and one write-through, receive the same kind of stimulus. Cold misses, hits of both commands, and store hits that dirty a line are each checked against the reply timing. Conflict misses on dirty and on clean victims tell apart whether a write-back is issued. One dirty eviction runs with the parent stalled, which shows that both queued requests survive and drain in order. The parent always acknowledges writes, so a controller that advanced on the write acknowledge under write-back would reply early. The write-through store cases show whether the write is forwarded before the count (on a hit) or after the fill (on a miss).

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FETCH,
        ST_WAIT,
        ST_WTHRU,
        ST_COUNT
    } cfc_state_e;

    localparam logic CMD_LOAD  = 1'b0;
    localparam logic CMD_STORE = 1'b1;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/cfc_tag_store.sv
module cfc_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             mark_dirty,
    input  logic             drop,
    input  logic             fill,
    input  logic             fill_dirty
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic sel;
        assign sel = (lk_idx == IDX_W'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[s] <= 1'b0;
                dirty_q[s] <= 1'b0;
                tag_q[s]   <= '0;
            end else if (sel) begin
                if (fill) begin
                    valid_q[s] <= 1'b1;
                    dirty_q[s] <= fill_dirty;
                    tag_q[s]   <= lk_tag;
                end else if (drop) begin
                    valid_q[s] <= 1'b0;
                    dirty_q[s] <= 1'b0;
                end else if (mark_dirty) begin
                    dirty_q[s] <= 1'b1;
                end
            end
        end
    end

    assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign vic_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
    assign vic_tag   = tag_q[lk_idx];

endmodule

// File: rtl/cfc_countdown.sv
module cfc_countdown #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfc_par_queue.sv
module cfc_par_queue #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         not_empty,
    output logic [W-1:0] dout,
    output logic [1:0]   count
);
    logic [W-1:0] slot_q [2];
    logic [1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            slot_q[0] <= '0;
            slot_q[1] <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    slot_q[cnt_q[0]] <= din;
                    cnt_q <= cnt_q + 1'b1;
                end
                2'b01: begin
                    slot_q[0] <= slot_q[1];
                    cnt_q <= cnt_q - 1'b1;
                end
                2'b11: begin
                    if (cnt_q == 2'd1) begin
                        slot_q[0] <= din;
                    end else begin
                        slot_q[0] <= slot_q[1];
                        slot_q[1] <= din;
                    end
                end
                default: ;
            endcase
        end
    end

    assign not_empty = (cnt_q != '0);
    assign dout      = slot_q[0];
    assign count     = cnt_q;

endmodule

// File: rtl/l1_timing_ctrl.sv
module l1_timing_ctrl
    import cfc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int OFS_W      = 2,
    parameter int IDX_W      = 2,
    parameter int ID_W       = 3,
    parameter int LAT_LOAD   = 2,
    parameter int LAT_STORE  = 3,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_store,
    output logic [ID_W-1:0]   rsp_id,
    output logic              par_req_valid,
    input  logic              par_req_ready,
    output logic              par_req_write,
    output logic              par_req_store,
    output logic [ADDR_W-1:0] par_req_addr,
    input  logic              par_rsp_valid,
    input  logic              par_rsp_fetch
);
    localparam int TAG_W   = ADDR_W - OFS_W - IDX_W;
    localparam int LAT_MAX = (LAT_LOAD > LAT_STORE) ? LAT_LOAD : LAT_STORE;
    localparam int CNT_W   = cnt_width(LAT_MAX);

    typedef struct packed {
        logic              write;
        logic              store;
        logic [ADDR_W-1:0] addr;
    } par_req_t;

    localparam int PQ_W = $bits(par_req_t);

    cfc_state_e        state_q, state_d;
    logic              cur_store_q;
    logic [ID_W-1:0]   cur_id_q;
    logic [ADDR_W-1:0] cur_addr_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit, vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              ts_mark, ts_drop, ts_fill, ts_fill_dirty;

    logic              t_load, t_expired;
    logic [CNT_W-1:0]  t_val;

    logic              pq_push;
    par_req_t          pq_din, pq_dout;
    logic [1:0]        q_count;

    logic              accept;
    logic [ADDR_W-1:0] own_line;
    logic [ADDR_W-1:0] vic_line;

    function automatic logic [CNT_W-1:0] lat_of(input logic is_store);
        return is_store ? CNT_W'(LAT_STORE - 1) : CNT_W'(LAT_LOAD - 1);
    endfunction

    assign lk_addr  = (state_q == ST_IDLE) ? req_addr : cur_addr_q;
    assign lk_idx   = lk_addr[OFS_W +: IDX_W];
    assign lk_tag   = lk_addr[OFS_W + IDX_W +: TAG_W];
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign own_line = {cur_addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign vic_line = {vic_tag, lk_idx, {OFS_W{1'b0}}};

    cfc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .vic_dirty  (vic_dirty),
        .vic_tag    (vic_tag),
        .mark_dirty (ts_mark),
        .drop       (ts_drop),
        .fill       (ts_fill),
        .fill_dirty (ts_fill_dirty)
    );

    cfc_countdown #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    cfc_par_queue #(.W(PQ_W)) u_pq (
        .clk       (clk),
        .rst       (rst),
        .push      (pq_push),
        .din       (pq_din),
        .pop       (par_req_valid && par_req_ready),
        .not_empty (par_req_valid),
        .dout      (pq_dout),
        .count     (q_count)
    );

    always_comb begin
        state_d       = state_q;
        ts_mark       = 1'b0;
        ts_drop       = 1'b0;
        ts_fill       = 1'b0;
        ts_fill_dirty = 1'b0;
        t_load        = 1'b0;
        t_val         = lat_of(cur_store_q);
        pq_push       = 1'b0;
        pq_din        = '{write: 1'b1, store: CMD_STORE, addr: own_line};
        rsp_valid     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!lk_hit) begin
                        state_d = ST_EVICT;
                    end else if (req_store == CMD_STORE && !WRITE_BACK) begin
                        state_d = ST_WTHRU;
                    end else begin
                        ts_mark = (req_store == CMD_STORE);
                        t_load  = 1'b1;
                        t_val   = lat_of(req_store);
                        state_d = ST_COUNT;
                    end
                end
            end
            ST_EVICT: begin
                ts_drop = 1'b1;
                pq_push = 1'b1;
                if (vic_dirty) begin
                    pq_din  = '{write: 1'b1, store: CMD_STORE, addr: vic_line};
                    state_d = ST_FETCH;
                end else begin
                    pq_din  = '{write: 1'b0, store: cur_store_q, addr: own_line};
                    state_d = ST_WAIT;
                end
            end
            ST_FETCH: begin
                pq_push = 1'b1;
                pq_din  = '{write: 1'b0, store: cur_store_q, addr: own_line};
                state_d = ST_WAIT;
            end
            ST_WTHRU: begin
                pq_push = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (par_rsp_valid && par_rsp_fetch) begin
                    ts_fill       = 1'b1;
                    ts_fill_dirty = WRITE_BACK && (cur_store_q == CMD_STORE);
                    if (!WRITE_BACK && cur_store_q == CMD_STORE) begin
                        state_d = ST_WTHRU;
                    end else begin
                        t_load  = 1'b1;
                        state_d = ST_COUNT;
                    end
                end else if (par_rsp_valid && !WRITE_BACK) begin
                    t_load  = 1'b1;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (t_expired) begin
                    rsp_valid = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_store_q <= CMD_LOAD;
            cur_id_q    <= '0;
            cur_addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_store_q <= req_store;
                cur_id_q    <= req_id;
                cur_addr_q  <= req_addr;
            end
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_store     = cur_store_q;
    assign rsp_id        = cur_id_q;
    assign par_req_write = pq_dout.write;
    assign par_req_store = pq_dout.store;
    assign par_req_addr  = pq_dout.addr;

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              par_req_valid,
    input logic              par_req_ready,
    input logic              par_req_write,
    input logic [ADDR_W-1:0] par_req_addr,
    input logic              par_rsp_valid,
    input logic [1:0]        q_count
);
    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);  // R2

    AST_REPLY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);  // R2

    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);  // R3

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        par_req_valid |-> (par_req_addr[OFS_W-1:0] == '0));  // R4

    AST_NO_EARLY_REPLY: assert property (@(posedge clk) disable iff (rst)
        par_rsp_valid |=> !rsp_valid && !req_ready);  // R7

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (par_req_valid && !par_req_ready) |=>
            (par_req_valid && $stable(par_req_addr) && $stable(par_req_write)));  // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q_count <= 2'd2);  // R10

endmodule

bind l1_timing_ctrl cfc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .par_req_valid (par_req_valid),
    .par_req_ready (par_req_ready),
    .par_req_write (par_req_write),
    .par_req_addr  (par_req_addr),
    .par_rsp_valid (par_rsp_valid),
    .q_count       (q_count)
);

// File: tb/test_l1_timing_ctrl.sv
`timescale 1ns/1ps
module test_l1_timing_ctrl;
    localparam int AW = 12, OW = 2, IW = 2, DW = 3, LD = 2, STL = 3, PD = 3;
    localparam int TW = AW - OW - IW;

    logic clk = 1'b0, rst = 1'b1;
    always #4 clk = ~clk;

    logic mode = 1'b0;  // 0 = write-back instance, 1 = write-through instance
    logic req_valid = 1'b0, req_store = 1'b0;
    logic [DW-1:0] req_id = '0;
    logic [AW-1:0] req_addr = '0;
    logic par_rdy = 1'b1, prsp_v = 1'b0, prsp_f = 1'b0;

    logic a_rdy, a_rv, a_rs, a_pv, a_pw, a_ps, b_rdy, b_rv, b_rs, b_pv, b_pw, b_ps;
    logic [DW-1:0] a_rid, b_rid;
    logic [AW-1:0] a_pa, b_pa;

    l1_timing_ctrl #(.ADDR_W(AW), .OFS_W(OW), .IDX_W(IW), .ID_W(DW),
        .LAT_LOAD(LD), .LAT_STORE(STL), .WRITE_BACK(1'b1)) i_l1_timing_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid && !mode), .req_ready(a_rdy),
        .req_store(req_store), .req_id(req_id), .req_addr(req_addr),
        .rsp_valid(a_rv), .rsp_store(a_rs), .rsp_id(a_rid),
        .par_req_valid(a_pv), .par_req_ready(par_rdy && !mode), .par_req_write(a_pw),
        .par_req_store(a_ps), .par_req_addr(a_pa),
        .par_rsp_valid(prsp_v && !mode), .par_rsp_fetch(prsp_f));

    l1_timing_ctrl #(.ADDR_W(AW), .OFS_W(OW), .IDX_W(IW), .ID_W(DW),
        .LAT_LOAD(LD), .LAT_STORE(STL), .WRITE_BACK(1'b0)) i_l1_timing_ctrl_wt (
        .clk(clk), .rst(rst), .req_valid(req_valid && mode), .req_ready(b_rdy),
        .req_store(req_store), .req_id(req_id), .req_addr(req_addr),
        .rsp_valid(b_rv), .rsp_store(b_rs), .rsp_id(b_rid),
        .par_req_valid(b_pv), .par_req_ready(par_rdy && mode), .par_req_write(b_pw),
        .par_req_store(b_ps), .par_req_addr(b_pa),
        .par_rsp_valid(prsp_v && mode), .par_rsp_fetch(prsp_f));

    wire m_rdy = mode ? b_rdy : a_rdy;
    wire m_rv  = mode ? b_rv  : a_rv;
    wire m_rs  = mode ? b_rs  : a_rs;
    wire m_pv  = mode ? b_pv  : a_pv;
    wire m_pw  = mode ? b_pw  : a_pw;
    wire m_ps  = mode ? b_ps  : a_ps;
    wire [DW-1:0] m_rid = mode ? b_rid : a_rid;
    wire [AW-1:0] m_pa  = mode ? b_pa  : a_pa;

    int n_checks = 0, n_fail = 0, cycles = 0;

    // behavioural reference state: one tag table per instance
    logic          mv [2][1<<IW];
    logic          md [2][1<<IW];
    logic [TW-1:0] mt [2][1<<IW];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // One request; parent replies PD cycles after each pop; hold = parent stall cycles.
    task automatic run_req(input logic st, input logic [DW-1:0] id, input logic [AW-1:0] addr,
                           input int hold, input string req);
        logic [AW-1:0] ew_a [4];
        logic ew_w [4], ew_s [4];
        int n_exp = 0, k = 0, last = 0, lat, np = 0, nh = 0;
        int due [4];
        logic dkind [4];
        bit done = 0;
        int m = mode;
        logic [IW-1:0] ix = addr[OW +: IW];
        logic [TW-1:0] tg = addr[OW+IW +: TW];
        logic [AW-1:0] line = {addr[AW-1:OW], {OW{1'b0}}};
        bit wb = (mode == 1'b0);
        lat = st ? STL : LD;
        if (mv[m][ix] && mt[m][ix] == tg) begin
            if (st && wb) md[m][ix] = 1'b1;
            if (st && !wb) begin ew_w[n_exp] = 1; ew_s[n_exp] = 1; ew_a[n_exp] = line; n_exp++; end
        end else begin
            if (mv[m][ix] && md[m][ix]) begin
                ew_w[n_exp] = 1; ew_s[n_exp] = 1; ew_a[n_exp] = {mt[m][ix], ix, {OW{1'b0}}}; n_exp++;
            end
            ew_w[n_exp] = 0; ew_s[n_exp] = st; ew_a[n_exp] = line; n_exp++;
            mv[m][ix] = 1'b1; mt[m][ix] = tg; md[m][ix] = st && wb;
            if (st && !wb) begin ew_w[n_exp] = 1; ew_s[n_exp] = 1; ew_a[n_exp] = line; n_exp++; end
        end
        chk(m_rdy == 1'b1, {req, " R2 idle ready"}, m_rdy, 1);
        req_valid = 1'b1; req_store = st; req_id = id; req_addr = addr;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int t = 1; t < 300 && !done; t++) begin
            prsp_v = 1'b0;
            if (nh < np && due[nh] == t) begin
                prsp_v = 1'b1; prsp_f = dkind[nh]; nh++; last = t;
            end
            par_rdy = (t > hold);
            if (hold > 0 && t == hold && n_exp >= 2)
                chk(m_pv == 1'b1, {req, " R10 queued while stalled"}, m_pv, 1);
            #1;
            chk(m_rdy == 1'b0, {req, " R2 busy"}, m_rdy, 0);
            if (m_pv && par_rdy) begin
                if (k < n_exp) begin
                    chk(m_pw == ew_w[k], {req, " R4 R5 kind"}, m_pw, ew_w[k]);
                    chk(m_ps == ew_s[k], {req, " R4 command"}, m_ps, ew_s[k]);
                    chk(m_pa == ew_a[k], {req, " R5 R8 R9 address"}, m_pa, ew_a[k]);
                end else begin
                    chk(0, {req, " R6 unexpected parent request"}, m_pa, 0);
                end
                k++;
                due[np] = t + PD; dkind[np] = !m_pw; np++;
            end
            if (m_rv) begin
                chk(t == last + lat && k == n_exp, {req, " R3 R7 reply cycle"}, t, last + lat);
                chk(m_rid == id && m_rs == st, {req, " R3 reply fields"}, {m_rs, m_rid}, {st, id});
                done = 1;
            end
            @(posedge clk); @(negedge clk);
        end
        prsp_v = 1'b0; par_rdy = 1'b1;
        chk(done, {req, " R3 reply seen"}, done, 1);
        chk(m_rv == 1'b0 && m_rdy == 1'b1, {req, " R2 back to idle"}, {m_rv, m_rdy}, 2'b01);
    endtask

    initial begin
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < (1 << IW); j++) begin
                mv[i][j] = 0; md[i][j] = 0; mt[i][j] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(a_rdy && b_rdy, "R1 ready", {a_rdy, b_rdy}, 2'b11);
        chk(!a_rv && !b_rv && !a_pv && !b_pv, "R1 quiet", {a_rv, b_rv, a_pv, b_pv}, 0);
        // write-back instance
        mode = 1'b0;
        run_req(0, 3'd1, 12'h040, 0, "R11 cold load");
        run_req(0, 3'd2, 12'h040, 0, "R3 load hit");
        run_req(1, 3'd3, 12'h042, 0, "R6 store hit dirty");
        run_req(0, 3'd4, 12'h140, 4, "R5 R7 R10 dirty evict stalled");
        run_req(0, 3'd5, 12'h040, 0, "R6 clean victim");
        run_req(1, 3'd6, 12'h2C8, 0, "R6 store fill");
        run_req(0, 3'd7, 12'h0C8, 0, "R5 evict filled store");
        // write-through instance
        mode = 1'b1;
        @(negedge clk);
        run_req(0, 3'd1, 12'h080, 0, "R11 wt cold load");
        run_req(1, 3'd2, 12'h083, 0, "R8 wt store hit");
        run_req(0, 3'd3, 12'h180, 0, "R6 wt no victim write");
        run_req(1, 3'd4, 12'h301, 0, "R9 wt store miss");
        run_req(0, 3'd5, 12'h300, 0, "R3 wt load hit");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule